// File: doc/BRIEF.md
# Multimode Line Encoder for Coupled Bundles

This block sits in a transmitter in front of a group of N coupled lines. Each cycle it can take one symbol of N uncoded data bits and produce N drive codes, one per line. Each code is the product of a programmable N×N encoding matrix and the bit vector, so every data bit is carried on its own orthogonal propagation mode of the bundle. Far-end crosstalk between the lines then cancels at the receiver, which applies the inverse matrix.

A coefficient times a single bit is only an AND gate, so every line is a bank of gated coefficients feeding a balanced adder tree. The 2^N possible sums of a line are spaced unevenly. The encoder rounds each sum onto the uniform grid shared by the N identical M-bit DACs, shifts it to an unsigned midscale-offset code and clips it to the DAC range.

The coefficients are signed fixed-point values. They are loaded one at a time by row and column into a shadow bank. The working bank copies the shadow bank only at the edge that accepts a symbol, so no symbol is encoded with a mix of old and new coefficients.

Top module: `mm_line_encoder`

## Requirements
- R1: While rst_n is low, and at its release, out_valid is 0, out_codes is all zeros and every stored coefficient is zero.
- R2: A symbol accepted on a rising edge with in_valid high produces its codes and out_valid high after the second rising edge. A cycle with in_valid low gives out_valid low two edges later. Symbols may arrive on consecutive cycles.
- R3: The sum for line i is the total of coefficient (row i, column j) over every column j whose in_bits[j] is 1.
- R4: The code for a line is round(sum / 2^FRAC_W) + 2^(DAC_W-1), limited to 0 .. 2^DAC_W-1. An all-zero symbol therefore gives midscale on every line.
- R5: Rounding is half away from zero: +0.5 LSB rounds up, -0.5 LSB rounds down, and a remainder below one half is dropped.
- R6: Sums above the top of the grid give all-ones codes, and sums below the bottom give zero.
- R7: A write with cfg_we high stores cfg_data, a two's-complement value with FRAC_W fraction bits, at row cfg_row and column cfg_col. A write whose row or column is N_LINES or greater changes nothing.
- R8: A symbol uses the coefficients written on edges before the edge that accepted it. A write on the accepting edge, or while the symbol is in flight, applies only to later symbols.
- R9: When no symbol completes, out_codes keeps its previous value.
- R10: With a diagonal matrix (and always when N_LINES is 1), line i carries the rounded, offset value of coefficient (i,i) when bit i is 1 and midscale when it is 0.
- R11: The code of line i sits in out_codes[i*DAC_W +: DAC_W].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A symbol is offered this cycle |
| in_bits | input | N_LINES | Uncoded data bits; bit j selects matrix column j |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_row | input | IDX_W | Matrix row (output line) of the write |
| cfg_col | input | IDX_W | Matrix column (data bit) of the write |
| cfg_data | input | COEF_W | Signed fixed-point coefficient |
| out_valid | output | 1 | out_codes carries a new symbol |
| out_codes | output | N_LINES*DAC_W | Packed unsigned DAC codes, line 0 in the low bits |

## Verification
The bench builds two instances. The first has three lines, 5-bit DACs and 8-bit coefficients with three fraction bits. This size allows all eight bit patterns under a mixed matrix and under a matrix that saturates both ends, and it allows exact half-LSB sums of both signs. The second has a single line, a 3-bit DAC and 6-bit coefficients with two fraction bits. That case has an adder tree with no adders, and its full coefficient range overruns the DAC grid in both directions.

// File: rtl/mm_enc_pkg.sv
package mm_enc_pkg;

   // Width of a row or column index (at least one bit).
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Number of adder levels needed to reduce n terms to one.
   function automatic int tree_depth(input int n);
      return (n > 1) ? $clog2(n) : 0;
   endfunction

   // Internal sum width: one bit of growth per tree level plus guard.
   function automatic int sum_width(input int coef_w, input int n);
      return coef_w + tree_depth(n) + 1;
   endfunction

endpackage

// File: rtl/mm_coef_bank.sv
module mm_coef_bank
   import mm_enc_pkg::*;
#(
   parameter int N_LINES = 3,
   parameter int COEF_W  = 8,
   parameter int IDX_W   = 2
)(
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cfg_we,
   input  logic [IDX_W-1:0]                   cfg_row,
   input  logic [IDX_W-1:0]                   cfg_col,
   input  logic [COEF_W-1:0]                  cfg_data,
   input  logic                               take,
   output logic [N_LINES*N_LINES*COEF_W-1:0]  act_flat
);

   localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(N_LINES);

   logic [COEF_W-1:0] shadow [N_LINES][N_LINES];
   logic [COEF_W-1:0] active [N_LINES][N_LINES];
   logic              addr_ok;

   assign addr_ok = ({1'b0, cfg_row} < LIMIT) && ({1'b0, cfg_col} < LIMIT);

   // Shadow bank: collects writes at any time.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < N_LINES; r++)
            for (int c = 0; c < N_LINES; c++)
               shadow[r][c] <= '0;
      end else if (cfg_we && addr_ok) begin
         shadow[cfg_row][cfg_col] <= cfg_data;
      end
   end

   // Working bank: refreshed only on the edge that accepts a symbol.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < N_LINES; r++)
            for (int c = 0; c < N_LINES; c++)
               active[r][c] <= '0;
      end else if (take) begin
         active <= shadow;
      end
   end

   for (genvar r = 0; r < N_LINES; r++) begin : g_row
      for (genvar c = 0; c < N_LINES; c++) begin : g_col
         assign act_flat[(r*N_LINES + c)*COEF_W +: COEF_W] = active[r][c];
      end
   end

   assert_cfg_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && addr_ok) |=> shadow[$past(cfg_row)][$past(cfg_col)] == $past(cfg_data));

   assert_bank_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(act_flat));

endmodule

// File: rtl/mm_line_sum.sv
module mm_line_sum
   import mm_enc_pkg::*;
#(
   parameter int N_LINES = 3,
   parameter int COEF_W  = 8,
   parameter int SUM_W   = 11
)(
   input  logic [N_LINES-1:0]         bits,
   input  logic [N_LINES*COEF_W-1:0]  row_coefs,
   output logic signed [SUM_W-1:0]    sum
);

   localparam int LV     = tree_depth(N_LINES);
   localparam int LEAVES = 1 << LV;

   // Heap-ordered tree: node 1 is the root, leaves start at LEAVES.
   logic signed [SUM_W-1:0] node [1:2*LEAVES-1];

   for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
      if (k < N_LINES) begin : g_gated
         logic signed [COEF_W-1:0] coef;
         assign coef = row_coefs[k*COEF_W +: COEF_W];
         // One bit times a coefficient is a plain AND per bit.
         assign node[LEAVES + k] = {SUM_W{bits[k]}} & SUM_W'(coef);
      end else begin : g_pad
         assign node[LEAVES + k] = '0;
      end
   end

   for (genvar p = 1; p < LEAVES; p++) begin : g_add
      assign node[p] = node[2*p] + node[2*p + 1];
   end

   assign sum = node[1];

endmodule

// File: rtl/mm_dac_quant.sv
module mm_dac_quant #(
   parameter int SUM_W  = 11,
   parameter int FRAC_W = 3,
   parameter int DAC_W  = 5
)(
   input  logic signed [SUM_W-1:0] sum,
   output logic [DAC_W-1:0]        code
);

   localparam int QW = SUM_W + 2;
   localparam logic signed [QW-1:0] MID = QW'(2**(DAC_W-1));
   localparam logic signed [QW-1:0] TOP = QW'(2**DAC_W - 1);

   logic signed [QW-1:0] q;
   logic signed [QW-1:0] biased;

   if (FRAC_W == 0) begin : g_integer
      assign q = QW'(sum);
   end else begin : g_round
      localparam logic signed [QW-1:0] HALF = QW'(2**(FRAC_W-1));
      logic signed [QW-1:0] wide, mag, rnd;
      logic                 neg;
      assign wide = QW'(sum);
      assign neg  = sum[SUM_W-1];
      assign mag  = neg ? -wide : wide;
      assign rnd  = (mag + HALF) >>> FRAC_W;
      assign q    = neg ? -rnd : rnd;
   end

   always_comb begin
      biased = q + MID;
      if (biased[QW-1])
         code = '0;
      else if (biased > TOP)
         code = '1;
      else
         code = biased[DAC_W-1:0];
   end

endmodule

// File: rtl/mm_line_encoder.sv
module mm_line_encoder
   import mm_enc_pkg::*;
#(
   parameter int N_LINES = 3,
   parameter int DAC_W   = 5,
   parameter int COEF_W  = 8,
   parameter int FRAC_W  = 3,
   localparam int IDX_W  = idx_width(N_LINES)
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [N_LINES-1:0]          in_bits,
   input  logic                        cfg_we,
   input  logic [IDX_W-1:0]            cfg_row,
   input  logic [IDX_W-1:0]            cfg_col,
   input  logic [COEF_W-1:0]           cfg_data,
   output logic                        out_valid,
   output logic [N_LINES*DAC_W-1:0]    out_codes
);

   localparam int SUM_W = sum_width(COEF_W, N_LINES);
   localparam int ROW_W = N_LINES * COEF_W;
   localparam logic [DAC_W-1:0] MID_CODE = DAC_W'(2**(DAC_W-1));
   localparam logic [N_LINES*DAC_W-1:0] MID_ALL = {N_LINES{MID_CODE}};

   // Elaboration-time parameter checks.
   if (N_LINES < 1) begin : g_chk_lines
      $error("mm_line_encoder: N_LINES must be at least 1");
   end
   if (DAC_W <= N_LINES) begin : g_chk_dac
      $error("mm_line_encoder: DAC_W must exceed N_LINES");
   end
   if (COEF_W < 2) begin : g_chk_coef
      $error("mm_line_encoder: COEF_W must be at least 2");
   end
   if (FRAC_W < 0 || FRAC_W >= COEF_W) begin : g_chk_frac
      $error("mm_line_encoder: FRAC_W must lie in 0..COEF_W-1");
   end

   logic                          s1_valid;
   logic [N_LINES-1:0]            s1_bits;
   logic [N_LINES*ROW_W-1:0]      act_flat;
   logic signed [SUM_W-1:0]       line_sum  [N_LINES];
   logic [DAC_W-1:0]              line_code [N_LINES];

   // Stage 1: register the symbol.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_bits  <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) s1_bits <= in_bits;
      end
   end

   mm_coef_bank #(
      .N_LINES (N_LINES),
      .COEF_W  (COEF_W),
      .IDX_W   (IDX_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_row  (cfg_row),
      .cfg_col  (cfg_col),
      .cfg_data (cfg_data),
      .take     (in_valid),
      .act_flat (act_flat)
   );

   for (genvar i = 0; i < N_LINES; i++) begin : g_line
      mm_line_sum #(
         .N_LINES (N_LINES),
         .COEF_W  (COEF_W),
         .SUM_W   (SUM_W)
      ) u_sum (
         .bits      (s1_bits),
         .row_coefs (act_flat[i*ROW_W +: ROW_W]),
         .sum       (line_sum[i])
      );

      mm_dac_quant #(
         .SUM_W  (SUM_W),
         .FRAC_W (FRAC_W),
         .DAC_W  (DAC_W)
      ) u_quant (
         .sum  (line_sum[i]),
         .code (line_code[i])
      );
   end

   // Stage 2: register the quantized codes.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_codes <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            for (int i = 0; i < N_LINES; i++)
               out_codes[i*DAC_W +: DAC_W] <= line_code[i];
         end
      end
   end

   assert_fill_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

   assert_gap_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> ##2 !out_valid);

   assert_hold_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> $stable(out_codes));

   assert_zero_midscale_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_bits == '0) |=> (out_codes == MID_ALL));

endmodule

// File: tb/mm_line_encoder_tb.sv
module mm_line_encoder_tb;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic        rst_n = 1'b0;
   // three-line instance
   logic        in_valid = 1'b0;
   logic [2:0]  in_bits  = '0;
   logic        cfg_we   = 1'b0;
   logic [1:0]  cfg_row  = '0;
   logic [1:0]  cfg_col  = '0;
   logic [7:0]  cfg_data = '0;
   logic        out_valid;
   logic [14:0] out_codes;
   // single-line instance
   logic        in1_valid = 1'b0;
   logic [0:0]  in1_bits  = '0;
   logic        cfg1_we   = 1'b0;
   logic [0:0]  cfg1_row  = '0;
   logic [0:0]  cfg1_col  = '0;
   logic [5:0]  cfg1_data = '0;
   logic        out1_valid;
   logic [2:0]  out1_codes;

   mm_line_encoder #(.N_LINES(3), .DAC_W(5), .COEF_W(8), .FRAC_W(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
      .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_data(cfg_data),
      .out_valid(out_valid), .out_codes(out_codes));

   mm_line_encoder #(.N_LINES(1), .DAC_W(3), .COEF_W(6), .FRAC_W(2)) u_dut_n1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in1_valid), .in_bits(in1_bits),
      .cfg_we(cfg1_we), .cfg_row(cfg1_row), .cfg_col(cfg1_col), .cfg_data(cfg1_data),
      .out_valid(out1_valid), .out_codes(out1_codes));

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int tm [3][3];

   // {matrix id, bit pattern}
   localparam int VEC [16][2] = '{
      '{0, 3'b101}, '{0, 3'b000}, '{0, 3'b111}, '{0, 3'b010},
      '{0, 3'b001}, '{0, 3'b110}, '{0, 3'b100}, '{0, 3'b011},
      '{1, 3'b111}, '{1, 3'b001}, '{1, 3'b010}, '{1, 3'b100},
      '{1, 3'b011}, '{1, 3'b110}, '{1, 3'b000}, '{1, 3'b101}};

   localparam int MAT [2][9] = '{
      '{10, -6, 3, -6, 12, -5, 3, -5, 9},
      '{127, 127, 127, -128, -128, -128, 100, -20, -100}};

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic int qref(input int s, input int f, input int m);
      int half, q, c;
      half = (f > 0) ? (1 << (f - 1)) : 0;
      if (s >= 0) q = (s + half) >>> f;
      else        q = -((-s + half) >>> f);
      c = q + (1 << (m - 1));
      if (c < 0) c = 0;
      if (c > (1 << m) - 1) c = (1 << m) - 1;
      return c;
   endfunction

   function automatic logic [14:0] exp_main(input logic [2:0] b);
      logic [14:0] e;
      e = '0;
      for (int i = 0; i < 3; i++) begin
         int s;
         s = 0;
         for (int j = 0; j < 3; j++) if (b[j]) s += tm[i][j];
         e[i*5 +: 5] = 5'(qref(s, 3, 5));
      end
      return e;
   endfunction

   task automatic write_coef(input int r, input int c, input int v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_row = 2'(r); cfg_col = 2'(c); cfg_data = 8'(v);
      @(negedge clk);
      cfg_we = 1'b0;
      if (r < 3 && c < 3) tm[r][c] = v;
   endtask

   task automatic load_mat(input int id);
      for (int k = 0; k < 9; k++) write_coef(k / 3, k % 3, MAT[id][k]);
   endtask

   task automatic apply(input logic [2:0] b, input string tag);
      logic [14:0] e;
      e = exp_main(b);
      @(negedge clk); in_valid = 1'b1; in_bits = b;
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      chk(tag, {16'd0, out_valid, out_codes}, {16'd0, 1'b1, e});
   endtask

   task automatic apply1(input int coef, input int exp_code, input logic b, input string tag);
      @(negedge clk); cfg1_we = 1'b1; cfg1_row = '0; cfg1_col = '0; cfg1_data = 6'(coef);
      @(negedge clk); cfg1_we = 1'b0; in1_valid = 1'b1; in1_bits = b;
      @(negedge clk); in1_valid = 1'b0;
      @(negedge clk);
      chk(tag, {28'd0, out1_valid, out1_codes}, {28'd0, 1'b1, 3'(exp_code)});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) tm[r][c] = 0;
      repeat (3) @(negedge clk);
      chk("R1 in reset", {16'd0, out_valid, out_codes}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", {16'd0, out_valid, out_codes}, 32'd0);
      chk("R1 single line", {28'd0, out1_valid, out1_codes}, 32'd0);
      // R1/R4: zero bank gives midscale on all lines
      apply(3'b111, "R1 R4 zero bank midscale");

      // R3 R4 R5 R6 R11: table walk
      for (int v = 0; v < 16; v++) begin
         if (v == 0 || VEC[v][0] != VEC[v-1][0]) load_mat(VEC[v][0]);
         apply(3'(VEC[v][1]), (VEC[v][0] == 0) ? "R3 R5 mixed matrix" : "R6 saturating matrix");
      end

      // R6 literal: line0 clips high, line1 clips low (matrix 1 loaded)
      apply(3'b111, "R6 clip ends");
      chk("R6 literal", {17'd0, out_codes[9:0]}, {17'd0, 5'd0, 5'd31});

      // R2: latency and back-to-back symbols
      load_mat(0);
      begin
         logic [14:0] e [3];
         for (int k = 0; k < 3; k++) e[k] = exp_main(3'(k + 5));
         @(negedge clk); in_valid = 1'b1; in_bits = 3'd5;
         @(negedge clk); in_bits = 3'd6;
         chk("R2 not after one edge", {31'd0, out_valid}, 32'd0);
         @(negedge clk); in_bits = 3'd7;
         chk("R2 stream 0", {16'd0, out_valid, out_codes}, {16'd0, 1'b1, e[0]});
         @(negedge clk); in_valid = 1'b0;
         chk("R2 stream 1", {16'd0, out_valid, out_codes}, {16'd0, 1'b1, e[1]});
         @(negedge clk);
         chk("R2 stream 2", {16'd0, out_valid, out_codes}, {16'd0, 1'b1, e[2]});
         @(negedge clk);
         chk("R2 gap drops valid", {31'd0, out_valid}, 32'd0);
         // R9: codes hold while idle
         repeat (3) @(negedge clk);
         chk("R9 hold", {17'd0, out_codes}, {17'd0, e[2]});
      end

      // R8: writes on the accepting edge and in flight apply later
      begin
         logic [14:0] e_old;
         e_old = exp_main(3'b111);
         @(negedge clk);
         in_valid = 1'b1; in_bits = 3'b111;
         cfg_we = 1'b1; cfg_row = 2'd0; cfg_col = 2'd0; cfg_data = 8'd40;
         @(negedge clk);
         in_valid = 1'b0;
         cfg_row = 2'd1; cfg_col = 2'd1; cfg_data = 8'(-40);
         @(negedge clk);
         cfg_we = 1'b0;
         tm[0][0] = 40; tm[1][1] = -40;
         chk("R8 old coefficients used", {16'd0, out_valid, out_codes}, {16'd0, 1'b1, e_old});
         apply(3'b111, "R8 new coefficients used");
      end

      // R7: address mapping and out-of-range writes
      for (int k = 0; k < 9; k++) write_coef(k / 3, k % 3, 0);
      write_coef(2, 0, 8);
      apply(3'b001, "R7 row2 col0");
      chk("R7 R11 literal", {17'd0, out_codes}, {17'd0, 5'd17, 5'd16, 5'd16});
      write_coef(3, 0, 100);
      write_coef(0, 3, 100);
      apply(3'b001, "R7 out-of-range ignored");
      chk("R7 ignored literal", {17'd0, out_codes}, {17'd0, 5'd17, 5'd16, 5'd16});

      // R5 R10: diagonal matrix with half-LSB values
      write_coef(2, 0, 0);
      write_coef(0, 0, 12);
      write_coef(1, 1, -12);
      write_coef(2, 2, -4);
      apply(3'b111, "R5 R10 diagonal");
      chk("R5 R10 literal 111", {17'd0, out_codes}, {17'd0, 5'd15, 5'd14, 5'd18});
      apply(3'b101, "R10 diagonal partial");
      chk("R10 literal 101", {17'd0, out_codes}, {17'd0, 5'd15, 5'd16, 5'd18});

      // R10 single line: N_LINES = 1, F = 2, 3-bit DAC
      apply1(2,   5, 1'b1, "R10 R5 n1 +0.5");
      apply1(2,   4, 1'b0, "R10 n1 bit clear");
      apply1(-2,  3, 1'b1, "R10 R5 n1 -0.5");
      apply1(6,   6, 1'b1, "R10 R5 n1 +1.5");
      apply1(-6,  2, 1'b1, "R10 R5 n1 -1.5");
      apply1(31,  7, 1'b1, "R6 n1 clip high");
      apply1(-32, 0, 1'b1, "R6 n1 clip low");

      finish_run();
   end

endmodule